// File: doc/BRIEF.md
# Fractional-N Divide Modulus Controller

This block drives the feedback counter of a fractional-N frequency synthesizer. It runs on the divider's input clock. It counts out one division at a time, and at the end of each division it picks the length of the next one. That length is the integer setting `N` plus a small signed step chosen by a digital sigma-delta modulator. The average division ratio therefore equals `N` plus a binary fraction, `fracWord / 2^FW`.

A mode input selects one of two modulators. In first-order mode a single accumulator adds the fraction once per division, and its overflow lengthens the next division by one clock. This gives a strictly repeating pattern of `N` and `N+1`. In second-order mode two accumulators are cascaded. The overflow of the second stage is differenced against its value from the previous division, which cancels that stage's own contribution over time. The step then ranges from -1 to +2 and the pattern is dithered, while the long-run average stays the same. The noise transfer is `(1 - z^-1)^m` for order `m`, and the signal transfer is unity.

Top module: `fracn_modctl`

## Requirements
- R1: In first-order mode, over any `2^FW` consecutive divisions the division lengths add up to exactly `2^FW*N + fracWord`.
- R2: In first-order mode every division lasts `N` or `N+1` cycles. An accumulator of `FW` bits, cleared by reset and wrapping modulo `2^FW`, adds `fracWord` at each division boundary, and its overflow selects `N+1` for the division that starts at that boundary.
- R3: With `fracWord = 2^(FW-2)` (one quarter) in first-order mode, the divisions after reset repeat as `N, N, N, N+1`.
- R4: In first-order mode the sequence of division lengths is periodic with period `2^FW` divisions.
- R5: In second-order mode (`orderSel = 1`) the step is `c1 + c2 - c2prev`. Here `c1` is the overflow of the first accumulator, `c2` is the overflow of a second accumulator that adds the first one's updated value, and `c2prev` is `c2` from the previous boundary. Over `2^FW` divisions the sum of lengths is within one of `2^FW*N + fracWord`.
- R6: In second-order mode every division lasts between `N-1` and `N+2` cycles. `N` must be at least 3.
- R7: `intDiv`, `fracWord` and `orderSel` are used only at a division boundary. `divValue` changes only at a boundary, so a division already in progress is never altered.
- R8: While `orderSel = 0`, the second accumulator and the stored `c2prev` are held at zero, so a later switch to second order starts from a cleared second stage.
- R9: Reset drives `divValue` to 0 and `fbPulse` to 0. The first division starts at the first clock edge after reset is released. `divValue` holds the length of the division in progress, that division lasts `divValue` cycles, and `fbPulse` is high on exactly its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intDiv | input | IW | Integer divide setting N (at least 3) |
| fracWord | input | FW | Unsigned fraction, value / 2^FW |
| orderSel | input | 1 | 0 = first-order accumulator, 1 = second-order cascade |
| divValue | output | IW+1 | Length of the division in progress, in clocks |
| fbPulse | output | 1 | High on the last cycle of each division |

## Verification
A corrupted accumulator or a lost carry does not show up in any single division. It shows up as a shift in where the longer divisions fall, and then as a running sum that misses the target by the end of a `2^FW`-division window. The bench therefore compares each division's length and pulse position on every clock against an independent model, which catches the first wrong boundary. It also totals whole windows, so a small bias cannot hide. A stale `c2prev` or a second stage that is not cleared appears within one or two divisions after a mode switch, as a step that differs from the model's.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // strobes from the count control to the modulator datapath
  typedef struct packed {
    logic advance;   // division boundary: step the modulator, latch next modulus
    logic clrUpper;  // boundary in first-order mode: clear the second stage
    logic useUpper;  // second-order mode selected
  } ctlStrobe_t;
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  input  logic         clear,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sumWrap,
  output logic         carry
);
  logic [W-1:0] acc;
  logic [W:0]   fullSum;

  assign fullSum = {1'b0, acc} + {1'b0, addend};
  assign sumWrap = fullSum[W-1:0];
  assign carry   = fullSum[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        acc <= '0;
    else if (clear)   acc <= '0;
    else if (advance) acc <= sumWrap;
  end
endmodule

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          orderSel,
  input  logic [CW-1:0] nextMod,
  output ctlStrobe_t    strobe,
  output logic          fbPulse
);
  logic [CW-1:0] remain;   // cycles left in the current division after this one
  logic          running;
  logic          atEnd;

  assign atEnd = (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      running <= 1'b0;
    end else if (atEnd) begin
      remain  <= nextMod - CW'(1);
      running <= 1'b1;
    end else begin
      remain  <= remain - CW'(1);
    end
  end

  always_comb begin
    strobe.advance  = atEnd;
    strobe.clrUpper = atEnd && !orderSel;
    strobe.useUpper = orderSel;
  end

  assign fbPulse = running && atEnd;
endmodule

// File: rtl/fracn_dp.sv
module fracn_dp
  import fracn_pkg::*;
#(
  parameter int IW = 8,
  parameter int FW = 16,
  parameter int NSTAGE = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [IW-1:0]   intDiv,
  input  logic [FW-1:0]   fracWord,
  output logic [IW:0]     nextMod,
  output logic [IW:0]     divValue
);
  localparam int CW = IW + 1;

  logic [FW-1:0] stageIn  [NSTAGE];
  logic [FW-1:0] stageSum [NSTAGE];
  logic          stageCy  [NSTAGE];
  logic          c2Prev;
  logic [2:0]    stepVal;

  generate
    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stageIn[k] = fracWord;
        fracn_accum #(.W(FW)) uAcc (
          .clk(clk), .rstN(rstN), .advance(strobe.advance), .clear(1'b0),
          .addend(stageIn[k]), .sumWrap(stageSum[k]), .carry(stageCy[k]));
      end else begin : g_upper
        assign stageIn[k] = stageSum[k-1];
        fracn_accum #(.W(FW)) uAcc (
          .clk(clk), .rstN(rstN), .advance(strobe.advance), .clear(strobe.clrUpper),
          .addend(stageIn[k]), .sumWrap(stageSum[k]), .carry(stageCy[k]));
      end
    end
  endgenerate

  // noise-cancel: difference the second-stage carry against its last value
  always_comb begin
    if (strobe.useUpper)
      stepVal = {2'b00, stageCy[0]} + {2'b00, stageCy[1]} - {2'b00, c2Prev};
    else
      stepVal = {2'b00, stageCy[0]};
  end

  assign nextMod = {1'b0, intDiv} + {{(CW-3){stepVal[2]}}, stepVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Prev   <= 1'b0;
      divValue <= '0;
    end else if (strobe.advance) begin
      c2Prev   <= strobe.clrUpper ? 1'b0 : stageCy[1];
      divValue <= nextMod;
    end
  end
endmodule

// File: rtl/fracn_modctl.sv
module fracn_modctl
  import fracn_pkg::*;
#(
  parameter int IW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] intDiv,
  input  logic [FW-1:0] fracWord,
  input  logic          orderSel,
  output logic [IW:0]   divValue,
  output logic          fbPulse
);
  localparam int CW = IW + 1;

  ctlStrobe_t    strobe;
  logic [CW-1:0] nextMod;

  fracn_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .orderSel(orderSel), .nextMod(nextMod),
    .strobe(strobe), .fbPulse(fbPulse));

  fracn_dp #(.IW(IW), .FW(FW), .NSTAGE(2)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intDiv(intDiv),
    .fracWord(fracWord), .nextMod(nextMod), .divValue(divValue));
endmodule

// File: rtl/fracn_modctl_chk.sv
module fracn_modctl_chk #(
  parameter int IW = 8,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [IW-1:0] intDiv,
  input logic [FW-1:0] fracWord,
  input logic          orderSel,
  input logic [IW:0]   divValue,
  input logic          fbPulse
);
  localparam int CW = IW + 1;

  // R7: outside a boundary the modulus in progress never moves
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (divValue != '0 && !fbPulse) |=> $stable(divValue));

  // R6: a new division lies within N-1 .. N+2
  p_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> ((CW'(divValue + CW'(1)) >= {1'b0, $past(intDiv)}) &&
                 (divValue <= CW'({1'b0, $past(intDiv)} + CW'(2)))));

  // R2: first-order mode picks only N or N+1
  p_first_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fbPulse && !orderSel) |=> ((divValue == {1'b0, $past(intDiv)}) ||
                                (divValue == CW'({1'b0, $past(intDiv)} + CW'(1)))));

  // R9: every division spans at least two cycles, so end pulses never touch
  p_pulse_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  wire unusedIn = ^{fracWord};
endmodule

bind fracn_modctl fracn_modctl_chk #(.IW(IW), .FW(FW)) uChk (
  .clk(clk), .rstN(rstN), .intDiv(intDiv), .fracWord(fracWord),
  .orderSel(orderSel), .divValue(divValue), .fbPulse(fbPulse));

// File: tb/sim_fracn_modctl.sv
`timescale 1ns/1ps
module sim_fracn_modctl;
  localparam int IW   = 8;
  localparam int FW   = 10;
  localparam int MODV = 1 << FW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] nDiv = 8'd4;
  logic [FW-1:0] fWord = '0;
  logic          oSel = 1'b0;
  logic [IW:0]   divValue;
  logic          fbPulse;

  int nChecks = 0;
  int nFails  = 0;
  int segMis  = 0;
  int q[$];

  // behavioural reference state
  int mAcc1, mAcc2, mC2d, mRemain, mRun, mDiv;

  always #2 clk = ~clk;  // 250 MHz

  fracn_modctl #(.IW(IW), .FW(FW)) u0 (
    .clk(clk), .rstN(rstN), .intDiv(nDiv), .fracWord(fWord),
    .orderSel(oSel), .divValue(divValue), .fbPulse(fbPulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      segMis++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelLoad();
    int s1, s2, c1, c2, y;
    s1 = mAcc1 + int'(fWord);
    c1 = (s1 >= MODV) ? 1 : 0;
    mAcc1 = s1 % MODV;
    if (oSel) begin
      s2 = mAcc2 + mAcc1;
      c2 = (s2 >= MODV) ? 1 : 0;
      mAcc2 = s2 % MODV;
      y = c1 + c2 - mC2d;
      mC2d = c2;
    end else begin
      mAcc2 = 0;
      mC2d = 0;
      y = c1;
    end
    mDiv = int'(nDiv) + y;
    mRemain = mDiv - 1;
    mRun = 1;
  endtask

  // one clock: advance the model for the edge just taken, compare, log ends
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rstN) begin
      mAcc1 = 0; mAcc2 = 0; mC2d = 0; mRemain = 0; mRun = 0; mDiv = 0;
    end else if (mRemain == 0) modelLoad();
    else mRemain--;
    chk(int'(divValue) == mDiv, "R9 modulus", int'(divValue), mDiv);
    chk(int'(fbPulse) == ((mRun == 1 && mRemain == 0) ? 1 : 0), "R9 pulse",
        int'(fbPulse), (mRun == 1 && mRemain == 0) ? 1 : 0);
    if (fbPulse) q.push_back(int'(divValue));
  endtask

  task automatic doReset(input int n, input int f, input bit o);
    rstN = 1'b0;
    nDiv = IW'(n); fWord = FW'(f); oSel = o;
    repeat (2) tick();
    chk(divValue == '0 && fbPulse == 1'b0, "R9 reset", int'(divValue), 0);
    rstN = 1'b1;
    q.delete();
  endtask

  task automatic runDivs(input int k);
    while (q.size() < k) tick();
  endtask

  function automatic int sumRange(input int lo, input int hi);
    int s = 0;
    for (int i = lo; i < hi; i++) s += q[i];
    return s;
  endfunction

  initial begin
    int s;
    // first order, one quarter
    doReset(4, MODV / 4, 1'b0);
    runDivs(MODV);
    s = sumRange(0, MODV);
    chk(s == 4 * MODV + MODV / 4, "R1 quarter sum", s, 4 * MODV + MODV / 4);
    for (int k = 0; k < 16; k++)
      chk(q[k] == ((k % 4 == 3) ? 5 : 4), "R3 pattern", q[k], (k % 4 == 3) ? 5 : 4);
    for (int k = 0; k < MODV; k++)
      chk(q[k] == 4 || q[k] == 5, "R2 values", q[k], 4);

    // first order, odd fraction: exact sum and period
    doReset(7, 'h2B7, 1'b0);
    runDivs(2 * MODV);
    s = sumRange(0, MODV);
    chk(s == 7 * MODV + 'h2B7, "R1 odd sum", s, 7 * MODV + 'h2B7);
    s = sumRange(37, 37 + MODV);
    chk(s == 7 * MODV + 'h2B7, "R1 shifted window", s, 7 * MODV + 'h2B7);
    for (int k = 0; k < MODV; k++)
      chk(q[k] == q[k + MODV], "R4 period", q[k + MODV], q[k]);

    // largest fraction, smallest legal N
    doReset(3, MODV - 1, 1'b0);
    runDivs(MODV);
    s = sumRange(0, MODV);
    chk(s == 3 * MODV + MODV - 1, "R1 max fraction", s, 3 * MODV + MODV - 1);

    // second order
    doReset(6, 'h155, 1'b1);
    runDivs(MODV + 5);
    s = sumRange(0, MODV);
    chk(s >= 6 * MODV + 'h155 && s <= 6 * MODV + 'h155 + 1, "R5 sum", s, 6 * MODV + 'h155);
    s = sumRange(5, 5 + MODV);
    chk(s >= 6 * MODV + 'h155 - 1 && s <= 6 * MODV + 'h155 + 1, "R5 window", s, 6 * MODV + 'h155);
    for (int k = 0; k < MODV; k++)
      chk(q[k] >= 5 && q[k] <= 8, "R6 range", q[k], 6);

    // zero fraction, second order: plain integer division
    doReset(9, 0, 1'b1);
    runDivs(40);
    for (int k = 0; k < 40; k++) chk(q[k] == 9, "R6 zero fraction", q[k], 9);

    // inputs changed mid-division are ignored until the boundary
    doReset(20, 0, 1'b0);
    runDivs(1);
    repeat (3) tick();
    nDiv = 8'd30;
    fWord = FW'(MODV - 1);
    oSel = 1'b1;
    while (!fbPulse) begin
      tick();
      chk(divValue == 9'd20, "R7 hold", int'(divValue), 20);
    end
    tick();
    chk(divValue == 9'd30, "R7 new modulus", int'(divValue), 30);

    // mode switching clears the second stage
    doReset(5, 'h0C3, 1'b1);
    segMis = 0;
    runDivs(50);
    oSel = 1'b0;
    runDivs(70);
    oSel = 1'b1;
    runDivs(130);
    chk(segMis == 0, "R8 mode switch", segMis, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule